// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block forms a 20-bit physical byte address for every memory access a processor core makes. It keeps four 16-bit segment base registers: code, stack, data and extra. It picks one of them from the kind of access being made. The chosen base is multiplied by sixteen and added to a 16-bit offset. That offset is the instruction pointer, the stack pointer, or an effective offset built from base, index and displacement values according to an addressing mode.

Data accesses may name a different segment through an override request. Fetches and push/pop stack accesses always use their fixed segment. The address path is purely combinational. The segment registers load on the clock through a single write port, so a base written in one cycle takes effect on the following cycle.

Top module: `seg_addr_gen`

## Requirements
- R1: `physAddr` equals (segment base × 16 + offset) modulo 2^20, computed combinationally from the current inputs and the current segment register contents.
- R2: After reset all four segment registers are zero, so `physAddr` equals the 16-bit offset zero-extended.
- R3: When `segWrEn` is 1 at a rising clock edge, the register selected by `segWrSel` (0 code, 1 stack, 2 data, 3 extra) loads `segWrData`. An access made in the same cycle as the write still uses the old value. The new value is used from the next cycle on.
- R4: With `accKind` = 0 (fetch), the code segment is used and the offset is `ipIn`.
- R5: With `accKind` = 1 (push/pop), the stack segment is used and the offset is `spIn`.
- R6: With `accKind` = 2 (data), the data segment is the default. When `baseIsBp` is 1 and the mode adds the base value (modes 1, 3 and 5), the default becomes the stack segment.
- R7: With `accKind` = 3 (destination data), the extra segment is the default.
- R8: With `ovrEn` = 1, `ovrSel` (same coding as `segWrSel`) replaces the default segment for kinds 2 and 3. The override is ignored for kinds 0 and 1.
- R9: For kinds 2 and 3, `addrMode` forms the offset modulo 2^16 as follows:
  - 0: disp
  - 1: base
  - 2: index
  - 3: base+disp
  - 4: index+disp
  - 5: base+index+disp
  - 6 and 7: disp
- R10: A carry out of address bit 19 is dropped, so addresses wrap within the 1 MB space. For example, base FFFF with offset FFFF gives 0FFEF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the segment register write port |
| rstN | input | 1 | Asynchronous active-low reset, clears the segment registers |
| accKind | input | 2 | Access kind: 0 fetch, 1 push/pop, 2 data, 3 destination data |
| addrMode | input | 3 | Effective offset mode for data kinds |
| baseIsBp | input | 1 | The base value comes from the frame (base) pointer |
| ovrEn | input | 1 | Segment override request |
| ovrSel | input | 2 | Segment named by the override |
| ipIn | input | 16 | Instruction pointer |
| spIn | input | 16 | Stack pointer |
| baseIn | input | 16 | Base register value |
| indexIn | input | 16 | Index register value |
| dispIn | input | 16 | Displacement |
| segWrEn | input | 1 | Segment register write enable |
| segWrSel | input | 2 | Segment register to write |
| segWrData | input | 16 | Value to write |
| physAddr | output | 20 | Physical byte address |

## Verification
Two things can fall in the same cycle: a segment register write and an access that reads the register being written. The bench provokes this in directed steps and in a long random run, where writes hit the selected segment while accesses are under way. Each cycle's address is judged against a model that applies writes only after the cycle's comparison. This holds the design to the old base in the write cycle and to the new base from the next cycle on. Wrap cases for the offset sum and for the 20-bit sum are judged in the same comparisons.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  localparam int NUM_SEG = 4;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_STACK = 2'd1,
    KIND_DATA  = 2'd2,
    KIND_DEST  = 2'd3
  } accKind_e;

  typedef enum logic [2:0] {
    MODE_DIRECT          = 3'd0,
    MODE_BASE            = 3'd1,
    MODE_INDEX           = 3'd2,
    MODE_BASE_DISP       = 3'd3,
    MODE_INDEX_DISP      = 3'd4,
    MODE_BASE_INDEX_DISP = 3'd5,
    MODE_RSVD6           = 3'd6,
    MODE_RSVD7           = 3'd7
  } addrMode_e;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_STACK = 2'd1,
    SEG_DATA  = 2'd2,
    SEG_EXTRA = 2'd3
  } segId_e;

  typedef enum logic [1:0] {
    OFF_IP   = 2'd0,
    OFF_SP   = 2'd1,
    OFF_MODE = 2'd2
  } offSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    segId_e  segSel;
    offSrc_e offSrc;
    logic    useBase;
    logic    useIndex;
    logic    useDisp;
  } addrCtl_t;

endpackage

// File: rtl/seg_addr_ctl.sv
module seg_addr_ctl
  import seg_addr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  accKind_e  kind,
  input  addrMode_e mode,
  input  logic      baseIsBp,
  input  logic      ovrEn,
  input  segId_e    ovrSel,
  output addrCtl_t  ctl
);

  logic   modeUsesBase;
  segId_e defaultSeg;

  // which terms the mode adds
  always_comb begin
    ctl.useBase  = 1'b0;
    ctl.useIndex = 1'b0;
    ctl.useDisp  = 1'b0;
    unique case (mode)
      MODE_BASE:            ctl.useBase = 1'b1;
      MODE_INDEX:           ctl.useIndex = 1'b1;
      MODE_BASE_DISP:       begin ctl.useBase = 1'b1; ctl.useDisp = 1'b1; end
      MODE_INDEX_DISP:      begin ctl.useIndex = 1'b1; ctl.useDisp = 1'b1; end
      MODE_BASE_INDEX_DISP: begin
        ctl.useBase  = 1'b1;
        ctl.useIndex = 1'b1;
        ctl.useDisp  = 1'b1;
      end
      default:              ctl.useDisp = 1'b1;  // direct and reserved codes
    endcase
  end

  assign modeUsesBase = (mode == MODE_BASE) || (mode == MODE_BASE_DISP) ||
                        (mode == MODE_BASE_INDEX_DISP);

  // implicit segment and offset source per access kind
  always_comb begin
    unique case (kind)
      KIND_FETCH: begin defaultSeg = SEG_CODE;  ctl.offSrc = OFF_IP; end
      KIND_STACK: begin defaultSeg = SEG_STACK; ctl.offSrc = OFF_SP; end
      KIND_DATA: begin
        defaultSeg = (baseIsBp && modeUsesBase) ? SEG_STACK : SEG_DATA;
        ctl.offSrc = OFF_MODE;
      end
      default: begin defaultSeg = SEG_EXTRA; ctl.offSrc = OFF_MODE; end
    endcase
  end

  // override applies to the two data kinds only
  always_comb begin
    if (ovrEn && (kind == KIND_DATA || kind == KIND_DEST)) ctl.segSel = ovrSel;
    else                                                    ctl.segSel = defaultSeg;
  end

  // R8: override has no effect on fetch
  a_r8_fetch_ignores_ovr: assert property (@(posedge clk) disable iff (!rstN)
    (kind == KIND_FETCH) |-> (ctl.segSel == SEG_CODE && ctl.offSrc == OFF_IP));

  // R8: override has no effect on push/pop
  a_r8_stack_ignores_ovr: assert property (@(posedge clk) disable iff (!rstN)
    (kind == KIND_STACK) |-> (ctl.segSel == SEG_STACK && ctl.offSrc == OFF_SP));

  // R9: reserved modes behave as direct
  a_r9_reserved_direct: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RSVD6 || mode == MODE_RSVD7) |->
      (ctl.useDisp && !ctl.useBase && !ctl.useIndex));

endmodule

// File: rtl/seg_addr_dp.sv
module seg_addr_dp
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  addrCtl_t                   ctl,
  input  logic [OFF_W-1:0]           ipIn,
  input  logic [OFF_W-1:0]           spIn,
  input  logic [OFF_W-1:0]           baseIn,
  input  logic [OFF_W-1:0]           indexIn,
  input  logic [OFF_W-1:0]           dispIn,
  input  logic                       wrEn,
  input  logic [$clog2(NUM_SEG)-1:0] wrSel,
  input  logic [SEG_W-1:0]           wrData,
  output logic [SEG_W+SHIFT-1:0]     physAddr
);

  localparam int PA_W  = SEG_W + SHIFT;
  localparam int SEL_W = $clog2(NUM_SEG);

  logic [SEG_W-1:0] segReg [NUM_SEG];
  logic [OFF_W-1:0] termBase, termIndex, termDisp;
  logic [OFF_W-1:0] modeOffset, offset;
  logic [SEG_W-1:0] segBase;

  // segment register file
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                               segReg[g] <= '0;
      else if (wrEn && wrSel == SEL_W'(g))     segReg[g] <= wrData;
    end
  end

  // effective offset, modulo 2^OFF_W
  assign termBase   = ctl.useBase  ? baseIn  : '0;
  assign termIndex  = ctl.useIndex ? indexIn : '0;
  assign termDisp   = ctl.useDisp  ? dispIn  : '0;
  assign modeOffset = termBase + termIndex + termDisp;

  always_comb begin
    unique case (ctl.offSrc)
      OFF_IP:  offset = ipIn;
      OFF_SP:  offset = spIn;
      default: offset = modeOffset;
    endcase
  end

  // relocation: shifted base plus offset, carry past the top bit dropped
  assign segBase  = segReg[ctl.segSel];
  assign physAddr = {segBase, {SHIFT{1'b0}}} + PA_W'(offset);

  // R3: a write lands in the selected register on the next cycle
  a_r3_seg_load: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (segReg[$past(wrSel)] == $past(wrData)));

  // R3: registers not written keep their value
  a_r3_seg_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn) |=> (segReg[$past(wrSel)] == $past(segReg[wrSel])));

  // R2: a zero base passes the offset straight through
  a_r2_zero_base: assert property (@(posedge clk) disable iff (!rstN)
    (segBase == '0) |-> (physAddr[PA_W-1:OFF_W] == '0));

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             accKind,
  input  logic [2:0]             addrMode,
  input  logic                   baseIsBp,
  input  logic                   ovrEn,
  input  logic [1:0]             ovrSel,
  input  logic [OFF_W-1:0]       ipIn,
  input  logic [OFF_W-1:0]       spIn,
  input  logic [OFF_W-1:0]       baseIn,
  input  logic [OFF_W-1:0]       indexIn,
  input  logic [OFF_W-1:0]       dispIn,
  input  logic                   segWrEn,
  input  logic [1:0]             segWrSel,
  input  logic [SEG_W-1:0]       segWrData,
  output logic [SEG_W+SHIFT-1:0] physAddr
);

  addrCtl_t ctl;

  seg_addr_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .kind     (accKind_e'(accKind)),
    .mode     (addrMode_e'(addrMode)),
    .baseIsBp (baseIsBp),
    .ovrEn    (ovrEn),
    .ovrSel   (segId_e'(ovrSel)),
    .ctl      (ctl)
  );

  seg_addr_dp #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .ipIn     (ipIn),
    .spIn     (spIn),
    .baseIn   (baseIn),
    .indexIn  (indexIn),
    .dispIn   (dispIn),
    .wrEn     (segWrEn),
    .wrSel    (segWrSel),
    .wrData   (segWrData),
    .physAddr (physAddr)
  );

endmodule

// File: tb/seg_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_addr_gen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  accKind = '0;
  logic [2:0]  addrMode = '0;
  logic        baseIsBp = 1'b0;
  logic        ovrEn = 1'b0;
  logic [1:0]  ovrSel = '0;
  logic [15:0] ipIn = '0, spIn = '0, baseIn = '0, indexIn = '0, dispIn = '0;
  logic        segWrEn = 1'b0;
  logic [1:0]  segWrSel = '0;
  logic [15:0] segWrData = '0;
  logic [19:0] physAddr;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 0;
  int mSeg [4];

  always #4 clk = ~clk;  // 125 MHz

  seg_addr_gen u_seg_addr_gen (
    .clk(clk), .rstN(rstN), .accKind(accKind), .addrMode(addrMode),
    .baseIsBp(baseIsBp), .ovrEn(ovrEn), .ovrSel(ovrSel), .ipIn(ipIn),
    .spIn(spIn), .baseIn(baseIn), .indexIn(indexIn), .dispIn(dispIn),
    .segWrEn(segWrEn), .segWrSel(segWrSel), .segWrData(segWrData),
    .physAddr(physAddr)
  );

  function automatic int expOffset();
    int o;
    if (accKind == 2'd0)      o = ipIn;
    else if (accKind == 2'd1) o = spIn;
    else begin
      case (addrMode)
        3'd1:    o = baseIn;
        3'd2:    o = indexIn;
        3'd3:    o = baseIn + dispIn;
        3'd4:    o = indexIn + dispIn;
        3'd5:    o = baseIn + indexIn + dispIn;
        default: o = dispIn;
      endcase
    end
    return o % 65536;
  endfunction

  function automatic int expSegIdx();
    if (accKind == 2'd0) return 0;
    if (accKind == 2'd1) return 1;
    if (ovrEn) return ovrSel;
    if (accKind == 2'd2)
      return (baseIsBp && (addrMode == 3'd1 || addrMode == 3'd3 || addrMode == 3'd5)) ? 1 : 2;
    return 3;
  endfunction

  function automatic logic [19:0] expPhys();
    return 20'((mSeg[expSegIdx()] * 16 + expOffset()) % 1048576);
  endfunction

  // compare mid-cycle, then let the edge apply any write to the model
  task automatic step(string tag);
    logic [19:0] e;
    #2;
    e = expPhys();
    checkCnt++;
    if (physAddr !== e) begin
      failCnt++;
      $display("FAIL %s kind=%0d mode=%0d actual=%05h expected=%05h",
               tag, accKind, addrMode, physAddr, e);
    end
    @(posedge clk);
    #1;
    if (segWrEn) mSeg[segWrSel] = segWrData;
    segWrEn = 1'b0;
  endtask

  task automatic access(logic [1:0] k, logic [2:0] m, logic bp, logic oe,
                        logic [1:0] os);
    accKind = k; addrMode = m; baseIsBp = bp; ovrEn = oe; ovrSel = os;
  endtask

  task automatic writeSeg(logic [1:0] s, logic [15:0] v);
    segWrEn = 1'b1; segWrSel = s; segWrData = v;
  endtask

  initial begin
    #(64'd8 * 200000);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mSeg[i] = 0;
    ipIn = 16'h1234; spIn = 16'hFFFE; baseIn = 16'h0100;
    indexIn = 16'h0020; dispIn = 16'h0003;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R2: reset state, all bases zero
    access(2'd0, 3'd0, 0, 0, 0); step("R2");
    access(2'd1, 3'd0, 0, 0, 0); step("R2");
    access(2'd2, 3'd5, 0, 0, 0); step("R2");
    access(2'd3, 3'd1, 0, 0, 0); step("R2");

    // R3: load each base; same-cycle access sees the old value
    access(2'd0, 3'd0, 0, 0, 0); writeSeg(2'd0, 16'h2000); step("R3");
    step("R4");
    access(2'd1, 3'd0, 0, 0, 0); writeSeg(2'd1, 16'h3000); step("R3");
    step("R5");
    access(2'd2, 3'd0, 0, 0, 0); writeSeg(2'd2, 16'h4000); step("R3");
    step("R6");
    access(2'd3, 3'd0, 0, 0, 0); writeSeg(2'd3, 16'h5000); step("R3");
    step("R7");

    // R9: every mode on data kind
    for (int m = 0; m < 8; m++) begin
      access(2'd2, 3'(m), 0, 0, 0); step("R9");
    end
    // R9: offset sum wraps modulo 2^16
    baseIn = 16'hFFF0; indexIn = 16'h0030; dispIn = 16'h8000;
    access(2'd3, 3'd5, 0, 0, 0); step("R9");
    access(2'd2, 3'd3, 0, 0, 0); step("R9");

    // R6: base-pointer based modes default to stack segment
    access(2'd2, 3'd1, 1, 0, 0); step("R6");
    access(2'd2, 3'd5, 1, 0, 0); step("R6");
    access(2'd2, 3'd4, 1, 0, 0); step("R6");

    // R8: override for data kinds, ignored for fetch and push/pop
    access(2'd2, 3'd0, 0, 1, 2'd3); step("R8");
    access(2'd3, 3'd2, 0, 1, 2'd0); step("R8");
    access(2'd2, 3'd1, 1, 1, 2'd2); step("R8");
    access(2'd0, 3'd0, 0, 1, 2'd3); step("R8");
    access(2'd1, 3'd0, 0, 1, 2'd2); step("R8");

    // R10 and R1: 20-bit wrap
    writeSeg(2'd0, 16'hFFFF); access(2'd1, 3'd0, 0, 0, 0); step("R1");
    ipIn = 16'hFFFF; access(2'd0, 3'd0, 0, 0, 0); step("R10");
    ipIn = 16'h0010; step("R10");

    // random run with writes colliding with accesses (R3, R1)
    for (int n = 0; n < 400; n++) begin
      access(2'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
      ipIn = 16'($urandom); spIn = 16'($urandom); baseIn = 16'($urandom);
      indexIn = 16'($urandom); dispIn = 16'($urandom);
      if ($urandom % 3 == 0) writeSeg(2'($urandom), 16'($urandom));
      if (segWrEn) step("R3");
      else         step("R1");
    end

    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule